// File: doc/BRIEF.md
# Dual-Path Oscillator Loop Filter Controller

This block is the digital loop filter of a phase-locked loop whose oscillator has two tuning inputs: a coarse word and a fine word. A fine word drives a two-step resistor/capacitor DAC. The block takes one signed phase-error sample on each reference-cycle strobe. A mode sequencer moves the block from reset to frequency acquisition and then to lock. During acquisition only the coarse word moves, and the fine word stays at mid-scale. Lock is reached when the coarse word has held still for a programmable number of strobes. From then on the coarse word is frozen, the fine path follows the error, and the enable for downstream noise cancellation is set.

The fine path is a lead-lag filter built from shift coefficients. It has an integrator that sets the zero, a proportional lead term, and a one-pole smoother that sets the first pole. It keeps extra fractional bits internally. A first-order error-feedback delta-sigma stage then rounds the fine value down to a 10-bit DAC code. The code is split into a ladder tap, which picks the two supply levels, and a count of unit capacitors placed on the upper level. After every strobe the block pulses a charge strobe, leaves one idle clock, and then pulses a share strobe.

Top module: `dual_path_lf`

## Requirements
- R1: While `rst` is high and after its release, until the first strobe: `mode` is 0 (reset), `coarse_word` is 128, `ladder_tap` is 16, `cap_count` is 0, and `charge_en`, `share_en` and `cancel_en` are low.
- R2: The first `ref_tick` seen in reset mode moves `mode` to 1 (acquisition) and leaves `coarse_word` unchanged.
- R3: In acquisition each `ref_tick` sets `coarse_word` to the old value plus `phase_err` arithmetically shifted right by 4, clamped to the range 0..255.
- R4: Outside lock mode the DAC code is mid-scale (`ladder_tap`=16, `cap_count`=0), whatever the error.
- R5: In acquisition a counter counts consecutive strobes on which `coarse_word` did not change. A changed word clears it. On the strobe where the count reaches `lock_len`, `mode` becomes 2 (lock). A `lock_len` of 0 acts as 1.
- R6: In lock `coarse_word` never changes. `cancel_en` is high exactly when `mode` is 2, and lock lasts until reset.
- R7: In lock, with Q6 fixed point, each strobe performs these steps: acc = clamp(acc + err, -32768, 32767); lead = acc + 16*err; y = clamp(y + ((lead - y) >>> 2), -32768, 32767). The filter state is cleared outside lock.
- R8: The delta-sigma stage forms s = (y + 32768) + r, where r is the 6-bit residue and starts at 0. The code is s >> 6 (or 1023 if s ≥ 65536), and the new r is s mod 64.
- R9: The fine code saturates at 1023 under sustained positive error and at 0 under sustained negative error.
- R10: `ladder_tap` is code[9:5] and `cap_count` is code[4:0].
- R11: After the clock edge that samples a strobe, `charge_en` is high for one cycle, then both strobes are low for one cycle, then `share_en` is high for one cycle. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference cycle |
| phase_err | input | 12 | Signed phase-error sample |
| lock_len | input | 8 | Unchanged-coarse strobes required for lock |
| coarse_word | output | 8 | Coarse oscillator tuning word |
| ladder_tap | output | 5 | DAC ladder level select (upper code bits) |
| cap_count | output | 5 | Unit capacitors on the upper level (lower code bits) |
| charge_en | output | 1 | DAC charge-phase strobe |
| share_en | output | 1 | DAC share-phase strobe |
| cancel_en | output | 1 | Noise-cancellation enable |
| mode | output | 2 | 0 reset, 1 acquisition, 2 lock |

## Verification
The hardest conditions to reach are the lock transition and the two saturation limits of the fine code. Random acquisition errors almost never leave the coarse word alone several strobes in a row, so directed runs supply errors in 0..15. One such run is broken by a single larger error to show that the streak count restarts. Saturation at 1023 and at 0 needs long runs of full-scale error of one sign. Each sign is driven until the code pins, and a reference model in the bench tracks the filter and delta-sigma residue on every strobe.

// File: rtl/dplf_pkg.sv
package dplf_pkg;

    localparam int DAC_W = 10;
    localparam int SEG_W = DAC_W / 2;

    typedef enum logic [1:0] {
        MD_RESET = 2'd0,
        MD_ACQ   = 2'd1,
        MD_LOCK  = 2'd2
    } lf_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_CHARGE = 2'd1,
        SQ_GAP    = 2'd2,
        SQ_SHARE  = 2'd3
    } dac_phase_e;

    typedef struct packed {
        logic [SEG_W-1:0] tap;
        logic [SEG_W-1:0] caps;
    } dac_word_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/lf_mode_fsm.sv
module lf_mode_fsm
    import dplf_pkg::*;
#(
    parameter int EW  = 12,
    parameter int CWD = 8,
    parameter int CSH = 4,
    parameter int LCW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic signed [EW-1:0] err,
    input  logic [LCW-1:0]       lock_len,
    output lf_mode_e             mode_q,
    output logic [CWD-1:0]       coarse_q
);
    localparam int CMAX = (1 << CWD) - 1;
    localparam logic [CWD-1:0] CMID = CWD'(1 << (CWD - 1));
    localparam logic [LCW-1:0] CNT_MAX = '1;

    logic [LCW-1:0] cnt_q, cnt_n, need;
    logic [CWD-1:0] coarse_n;
    int             c_sum;

    always_comb begin
        c_sum    = clamp_int(int'(coarse_q) + (int'(err) >>> CSH), 0, CMAX);
        coarse_n = CWD'(c_sum);
        if (coarse_n != coarse_q)  cnt_n = '0;
        else if (cnt_q == CNT_MAX) cnt_n = cnt_q;
        else                       cnt_n = cnt_q + 1'b1;
        need = (lock_len == '0) ? LCW'(1) : lock_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_RESET;
            coarse_q <= CMID;
            cnt_q    <= '0;
        end else if (tick) begin
            case (mode_q)
                MD_RESET: mode_q <= MD_ACQ;
                MD_ACQ: begin
                    coarse_q <= coarse_n;
                    cnt_q    <= cnt_n;
                    if (cnt_n >= need) mode_q <= MD_LOCK;
                end
                default: ;
            endcase
        end
    end

    p_lock_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        mode_q == MD_LOCK |=> mode_q == MD_LOCK && $stable(coarse_q));

    p_coarse_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(coarse_q) && $stable(mode_q));

endmodule

// File: rtl/lf_fine_path.sv
module lf_fine_path
    import dplf_pkg::*;
#(
    parameter int EW      = 12,
    parameter int FB      = 6,
    parameter int KI_SHL  = 0,
    parameter int KP_SHL  = 4,
    parameter int POLE_SH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 lock,
    input  logic signed [EW-1:0] err,
    output logic [DAC_W-1:0]     code_q
);
    localparam int FW  = DAC_W + FB;
    localparam int SW  = FW + 2;
    localparam int LIM = 1 << (FW - 1);
    localparam logic [DAC_W-1:0] MID = DAC_W'(1 << (DAC_W - 1));

    logic signed [SW-1:0] acc_q, y_q;
    logic [FB-1:0]        res_q;
    logic [DAC_W-1:0]     code_n;
    int acc_n, lead_i, y_n, sum_i;

    always_comb begin
        acc_n  = clamp_int(int'(acc_q) + (int'(err) <<< KI_SHL), -LIM, LIM - 1);
        lead_i = acc_n + (int'(err) <<< KP_SHL);
        y_n    = clamp_int(int'(y_q) + ((lead_i - int'(y_q)) >>> POLE_SH), -LIM, LIM - 1);
        sum_i  = y_n + LIM + int'(res_q);
        if (sum_i >= (1 << FW)) code_n = '1;
        else                    code_n = sum_i[FW-1:FB];
    end

    always_ff @(posedge clk) begin
        if (rst || !lock) begin
            acc_q  <= '0;
            y_q    <= '0;
            res_q  <= '0;
            code_q <= MID;
        end else if (tick) begin
            acc_q  <= SW'(acc_n);
            y_q    <= SW'(y_n);
            res_q  <= sum_i[FB-1:0];
            code_q <= code_n;
        end
    end

    p_code_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (lock && !tick) |=> $stable(code_q));

endmodule

// File: rtl/lf_dac_seq.sv
module lf_dac_seq
    import dplf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic charge_en,
    output logic share_en
);
    dac_phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= SQ_IDLE;
        else if (tick) ph_q <= SQ_CHARGE;
        else begin
            case (ph_q)
                SQ_CHARGE: ph_q <= SQ_GAP;
                SQ_GAP:    ph_q <= SQ_SHARE;
                default:   ph_q <= SQ_IDLE;
            endcase
        end
    end

    assign charge_en = (ph_q == SQ_CHARGE);
    assign share_en  = (ph_q == SQ_SHARE);

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        !(charge_en && share_en));

    p_share_after_charge_r11: assert property (@(posedge clk) disable iff (rst)
        share_en |-> $past(charge_en, 2) && !$past(charge_en));

endmodule

// File: rtl/dual_path_lf.sv
module dual_path_lf
    import dplf_pkg::*;
#(
    parameter int EW      = 12,
    parameter int CWD     = 8,
    parameter int CSH     = 4,
    parameter int LCW     = 8,
    parameter int FB      = 6,
    parameter int KI_SHL  = 0,
    parameter int KP_SHL  = 4,
    parameter int POLE_SH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_tick,
    input  logic signed [EW-1:0] phase_err,
    input  logic [LCW-1:0]       lock_len,
    output logic [CWD-1:0]       coarse_word,
    output logic [SEG_W-1:0]     ladder_tap,
    output logic [SEG_W-1:0]     cap_count,
    output logic                 charge_en,
    output logic                 share_en,
    output logic                 cancel_en,
    output logic [1:0]           mode
);
    lf_mode_e         mode_q;
    logic [DAC_W-1:0] code;
    dac_word_t        word;

    lf_mode_fsm #(.EW(EW), .CWD(CWD), .CSH(CSH), .LCW(LCW)) u_fsm (
        .clk(clk), .rst(rst), .tick(ref_tick), .err(phase_err),
        .lock_len(lock_len), .mode_q(mode_q), .coarse_q(coarse_word)
    );

    lf_fine_path #(.EW(EW), .FB(FB), .KI_SHL(KI_SHL), .KP_SHL(KP_SHL),
                   .POLE_SH(POLE_SH)) u_fine (
        .clk(clk), .rst(rst), .tick(ref_tick), .lock(mode_q == MD_LOCK),
        .err(phase_err), .code_q(code)
    );

    lf_dac_seq u_seq (
        .clk(clk), .rst(rst), .tick(ref_tick),
        .charge_en(charge_en), .share_en(share_en)
    );

    assign word       = code;
    assign ladder_tap = word.tap;
    assign cap_count  = word.caps;
    assign cancel_en  = (mode_q == MD_LOCK);
    assign mode       = mode_q;

    p_fine_mid_r4: assert property (@(posedge clk) disable iff (rst)
        mode_q != MD_LOCK |-> ladder_tap == SEG_W'(1 << (SEG_W - 1)) && cap_count == '0);

    p_code_held_share_r11: assert property (@(posedge clk) disable iff (rst)
        share_en |-> $stable(code));

endmodule

// File: tb/dual_path_lf_bench.sv
module dual_path_lf_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [11:0] phase_err = '0;
    logic [7:0]  lock_len = 8'd3;
    logic [7:0]  coarse_word;
    logic [4:0]  ladder_tap, cap_count;
    logic        charge_en, share_en, cancel_en;
    logic [1:0]  mode;

    int total = 0;
    int bad = 0;

    int m_mode, m_coarse, m_cnt, m_acc, m_y, m_res, m_code;

    always #5 clk = ~clk;

    dual_path_lf u_dual_path_lf (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .phase_err(phase_err),
        .lock_len(lock_len), .coarse_word(coarse_word), .ladder_tap(ladder_tap),
        .cap_count(cap_count), .charge_en(charge_en), .share_en(share_en),
        .cancel_en(cancel_en), .mode(mode)
    );

    function automatic int clampb(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_coarse = 128; m_cnt = 0;
        m_acc = 0; m_y = 0; m_res = 0; m_code = 512;
    endtask

    task automatic model_step(input int err, input int ll);
        int cn, lead, s, need;
        case (m_mode)
            0: m_mode = 1;
            1: begin
                cn = clampb(m_coarse + (err >>> 4), 0, 255);
                m_cnt = (cn == m_coarse) ? clampb(m_cnt + 1, 0, 255) : 0;
                m_coarse = cn;
                need = (ll == 0) ? 1 : ll;
                if (m_cnt >= need) m_mode = 2;
            end
            default: begin
                m_acc = clampb(m_acc + err, -32768, 32767);
                lead  = m_acc + err * 16;
                m_y   = clampb(m_y + ((lead - m_y) >>> 2), -32768, 32767);
                s     = m_y + 32768 + m_res;
                m_code = (s >= 65536) ? 1023 : (s >>> 6);
                m_res = s & 63;
            end
        endcase
    endtask

    task automatic do_tick(input int err, input int ll);
        @(negedge clk);
        ref_tick  = 1'b1;
        phase_err = err[11:0];
        lock_len  = ll[7:0];
        model_step(err, ll);
        @(negedge clk);
        ref_tick = 1'b0;
        check("R5 mode", int'(mode), m_mode);
        check("R3 coarse", int'(coarse_word), m_coarse);
        check("R10 tap", int'(ladder_tap), m_code >> 5);
        check("R10 caps", int'(cap_count), m_code & 31);
        check("R6 cancel", int'(cancel_en), (m_mode == 2) ? 1 : 0);
        check("R11 charge1", int'(charge_en), 1);
        check("R11 share1", int'(share_en), 0);
        @(negedge clk);
        check("R11 gap", int'(charge_en) + int'(share_en), 0);
        @(negedge clk);
        check("R11 share", int'(share_en), 1);
        check("R11 nooverlap", int'(charge_en), 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        check("R1 mode", int'(mode), 0);
        check("R1 coarse", int'(coarse_word), 128);
        check("R1 tap", int'(ladder_tap), 16);
        check("R1 caps", int'(cap_count), 0);
        check("R1 strobes", int'(charge_en) + int'(share_en) + int'(cancel_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'(mode), 0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        do_reset();

        // R2: first strobe leaves reset, coarse untouched
        do_tick(2047, 3);
        check("R2 mode acq", int'(mode), 1);
        check("R2 coarse kept", int'(coarse_word), 128);

        // R3: coarse up to saturation, then down to 0; R4 mid held
        do_tick(2047, 200);
        do_tick(2047, 200);
        check("R3 sat high", int'(coarse_word), 255);
        do_tick(-2048, 200);
        do_tick(-2048, 200);
        do_tick(-2048, 200);
        check("R3 sat low", int'(coarse_word), 0);
        for (int i = 0; i < 20; i++) begin
            int e;
            e = int'($urandom_range(4095)) - 2048;
            do_tick(e, 200);
            check("R4 mid tap", int'(ladder_tap), 16);
            check("R4 mid caps", int'(cap_count), 0);
        end
        do_tick(0, 200);
        do_tick(1000, 200);

        // R5: streak broken then completed
        do_tick(5, 3);
        do_tick(9, 3);
        check("R5 not yet", int'(mode), 1);
        do_tick(100, 3);
        do_tick(0, 3);
        do_tick(15, 3);
        check("R5 streak reset", int'(mode), 1);
        do_tick(2, 3);
        check("R5 locked", int'(mode), 2);
        check("R6 cancel on", int'(cancel_en), 1);

        // R6: coarse frozen
        begin
            int cw;
            cw = int'(coarse_word);
            do_tick(2047, 3);
            check("R6 frozen", int'(coarse_word), cw);
        end

        // R7, R8: random lock-mode tracking
        for (int i = 0; i < 30; i++) begin
            int e;
            e = int'($urandom_range(400)) - 200;
            do_tick(e, 3);
        end

        // R9: saturation both ways
        for (int i = 0; i < 12; i++) do_tick(2047, 3);
        check("R9 top", int'({ladder_tap, cap_count}), 1023);
        for (int i = 0; i < 40; i++) do_tick(-2048, 3);
        check("R9 bottom", int'({ladder_tap, cap_count}), 0);
        check("R6 still lock", int'(mode), 2);

        // R5: lock_len 0 acts as 1
        do_reset();
        do_tick(0, 0);
        do_tick(3, 0);
        check("R5 len0 lock", int'(mode), 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule